// File: doc/BRIEF.md
# One-Shot Event Flag Bank

This block holds 256 single-bit flags that carry one-to-one handoffs between engines. It is separate from any counting semaphore logic. A producer raises a flag. A consumer waits on that flag, and the wait lowers the flag again in the cycle it passes, so each raised flag releases exactly one waiter. Raising a flag that is already up is a protocol violation. Lowering a flag that is not up is also a protocol violation.

Two request ports share the bank. The producer port raises one flag per cycle. The consumer port issues one of three commands per cycle:

- wait-and-lower;
- lower;
- wait-then-raise, which waits on one flag, lowers it, and raises a second flag.

A wait that cannot pass reports a stall and leaves the bank unchanged, so the requester holds its request until it sees a grant. Grants and stalls depend only on the current flags and on the requests in the same cycle.

Violations are logged in a sticky error record that keeps the kind and the index of the first violation. A violating raise or lower leaves the flag it targets as it was.

Top module: `event_flag_bank`

## Requirements
- R1: After synchronous reset, err_flag is 0, err_code is 0 and err_idx is 0. A wait on any index stalls.
- R2: Each of the 256 flags is addressed by an 8-bit index and behaves independently. Raising one flag does not make a wait on any other index pass.
- R3: A consumer command with cons_op 2'b00 (wait-and-lower) on a raised flag asserts cons_grant in the same cycle and lowers that flag, so the next wait on it stalls.
- R4: A wait (cons_op 2'b00 or 2'b10) on a lowered flag asserts cons_stall, keeps cons_grant low, and changes no flag. cons_grant and cons_stall are never high together.
- R5: A producer raise on a flag that is already raised sets err_flag with err_code 2'b01 (double raise) and err_idx equal to the index. The flag stays raised exactly once, so it satisfies one wait only.
- R6: cons_op 2'b01 (lower) always grants. On a raised flag it lowers the flag without error. On a lowered flag it logs err_code 2'b10 (lower before raise) with that index and changes no flag.
- R7: cons_op 2'b10 (wait-then-raise) waits on cons_idx. When that flag is raised, the command grants, lowers cons_idx and raises cons_set_idx. If cons_set_idx is still raised after the lowering, the command logs a double raise on cons_set_idx, and the wait part still lowers cons_idx.
- R8: A producer raise and a consumer wait on the same lowered index in the same cycle resolve as raise-then-consume: the wait is granted and the flag ends lowered.
- R9: The error record is sticky. Once err_flag is set, err_code and err_idx keep the first violation until reset. When both ports violate in the same cycle, the producer's violation is the one recorded.
- R10: cons_op 2'b11 is reserved. It grants nothing, stalls nothing and changes no flag.
- R11: A synchronous reset lowers all 256 flags and clears the error record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_valid | input | 1 | Producer raise request |
| prod_idx | input | 8 | Flag to raise |
| cons_valid | input | 1 | Consumer command request |
| cons_op | input | 2 | 00 wait-and-lower, 01 lower, 10 wait-then-raise, 11 reserved |
| cons_idx | input | 8 | Flag waited on or lowered |
| cons_set_idx | input | 8 | Flag raised by wait-then-raise |
| cons_grant | output | 1 | Consumer command accepted this cycle |
| cons_stall | output | 1 | Consumer wait blocked this cycle |
| err_flag | output | 1 | Sticky protocol error |
| err_code | output | 2 | Kind of first error: 01 double raise, 10 lower before raise |
| err_idx | output | 8 | Index of first error |

## Verification
The bank's state can only be seen through waits and through the error record. A flag that is wrongly left up, or wrongly dropped, therefore shows up one cycle later: a following wait grants when it should stall, or stalls when it should grant. A spurious or missed double-raise error appears in err_flag on the clock edge that follows the request. A record that is overwritten after the first error shows up as a changed err_idx on a later violation. The directed scenarios probe each flag right after every command that could have changed it, so any wrong state surfaces within two cycles.

// File: rtl/evf_pkg.sv
package evf_pkg;
    localparam int unsigned EVF_FLAGS = 256;
    localparam int unsigned EVF_IDX_W = $clog2(EVF_FLAGS);

    typedef logic [EVF_IDX_W-1:0] evf_idx_t;
    typedef logic [EVF_FLAGS-1:0] evf_vec_t;

    typedef enum logic [1:0] {
        OP_WAIT_CLR = 2'b00,
        OP_CLEAR    = 2'b01,
        OP_WAIT_SET = 2'b10,
        OP_RSVD     = 2'b11
    } evf_op_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'b00,
        ERR_DUP_SET   = 2'b01,
        ERR_CLR_UNSET = 2'b10
    } evf_err_e;

    typedef struct packed {
        logic     vld;
        evf_err_e code;
        evf_idx_t idx;
    } evf_err_t;

    function automatic evf_err_t evf_mk_err(evf_err_e code, evf_idx_t idx);
        evf_err_t e;
        e.vld  = 1'b1;
        e.code = code;
        e.idx  = idx;
        return e;
    endfunction
endpackage

// File: rtl/evf_flag_store.sv
module evf_flag_store
    import evf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evf_vec_t flags_nxt,
    output evf_vec_t flags_q
);
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_nxt;
    end
endmodule

// File: rtl/evf_resolve.sv
module evf_resolve
    import evf_pkg::*;
(
    input  evf_vec_t   flags_q,
    input  logic       prod_valid,
    input  evf_idx_t   prod_idx,
    input  logic       cons_valid,
    input  logic [1:0] cons_op,
    input  evf_idx_t   cons_idx,
    input  evf_idx_t   cons_set_idx,
    output evf_vec_t   flags_nxt,
    output logic       grant,
    output logic       stall,
    output evf_err_t   prod_err,
    output evf_err_t   cons_err
);
    evf_vec_t mid;

    // Producer first: a raise is visible to a consumer wait in the same cycle.
    always_comb begin
        mid      = flags_q;
        prod_err = '0;
        if (prod_valid) begin
            if (flags_q[prod_idx]) prod_err = evf_mk_err(ERR_DUP_SET, prod_idx);
            mid[prod_idx] = 1'b1;
        end
    end

    always_comb begin
        flags_nxt = mid;
        grant     = 1'b0;
        stall     = 1'b0;
        cons_err  = '0;
        if (cons_valid) begin
            unique case (evf_op_e'(cons_op))
                OP_WAIT_CLR: begin
                    if (mid[cons_idx]) begin
                        grant               = 1'b1;
                        flags_nxt[cons_idx] = 1'b0;
                    end else begin
                        stall = 1'b1;
                    end
                end
                OP_CLEAR: begin
                    grant = 1'b1;
                    if (mid[cons_idx]) flags_nxt[cons_idx] = 1'b0;
                    else cons_err = evf_mk_err(ERR_CLR_UNSET, cons_idx);
                end
                OP_WAIT_SET: begin
                    if (mid[cons_idx]) begin
                        grant               = 1'b1;
                        flags_nxt[cons_idx] = 1'b0;
                        if (flags_nxt[cons_set_idx])
                            cons_err = evf_mk_err(ERR_DUP_SET, cons_set_idx);
                        else
                            flags_nxt[cons_set_idx] = 1'b1;
                    end else begin
                        stall = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/evf_err_log.sv
module evf_err_log
    import evf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evf_err_t prod_err,
    input  evf_err_t cons_err,
    output evf_err_t err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else if (!err_q.vld) begin
            if (prod_err.vld)      err_q <= prod_err;
            else if (cons_err.vld) err_q <= cons_err;
        end
    end

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_q.vld |=> err_q.vld);
    assert_err_hold_R9: assert property (@(posedge clk) disable iff (rst)
        err_q.vld |=> $stable(err_q.idx) && $stable(err_q.code));
endmodule

// File: rtl/event_flag_bank.sv
module event_flag_bank
    import evf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prod_valid,
    input  logic [EVF_IDX_W-1:0] prod_idx,
    input  logic                 cons_valid,
    input  logic [1:0]           cons_op,
    input  logic [EVF_IDX_W-1:0] cons_idx,
    input  logic [EVF_IDX_W-1:0] cons_set_idx,
    output logic                 cons_grant,
    output logic                 cons_stall,
    output logic                 err_flag,
    output logic [1:0]           err_code,
    output logic [EVF_IDX_W-1:0] err_idx
);
    evf_vec_t flags_q;
    evf_vec_t flags_nxt;
    evf_err_t prod_err;
    evf_err_t cons_err;
    evf_err_t err_q;

    evf_flag_store u_store (
        .clk       (clk),
        .rst       (rst),
        .flags_nxt (flags_nxt),
        .flags_q   (flags_q)
    );

    evf_resolve u_resolve (
        .flags_q      (flags_q),
        .prod_valid   (prod_valid),
        .prod_idx     (prod_idx),
        .cons_valid   (cons_valid),
        .cons_op      (cons_op),
        .cons_idx     (cons_idx),
        .cons_set_idx (cons_set_idx),
        .flags_nxt    (flags_nxt),
        .grant        (cons_grant),
        .stall        (cons_stall),
        .prod_err     (prod_err),
        .cons_err     (cons_err)
    );

    evf_err_log u_err (
        .clk      (clk),
        .rst      (rst),
        .prod_err (prod_err),
        .cons_err (cons_err),
        .err_q    (err_q)
    );

    assign err_flag = err_q.vld;
    assign err_code = err_q.code;
    assign err_idx  = err_q.idx;

    assert_grant_stall_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(cons_grant && cons_stall));
    assert_wait_consumes_R3: assert property (@(posedge clk) disable iff (rst)
        (cons_valid && cons_op == 2'b00 && cons_grant) |=> !flags_q[$past(cons_idx)]);
    assert_dup_keeps_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (prod_valid && flags_q[prod_idx] && !(cons_valid && cons_idx == prod_idx))
        |=> flags_q[$past(prod_idx)]);
    assert_reserved_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (cons_valid && cons_op == 2'b11) |-> (!cons_grant && !cons_stall));
    assert_reserved_no_change_R10: assert property (@(posedge clk) disable iff (rst)
        (cons_valid && cons_op == 2'b11 && !prod_valid) |=> $stable(flags_q));
endmodule

// File: tb/event_flag_bank_test.sv
module event_flag_bank_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prod_valid = 1'b0;
    logic [7:0] prod_idx = '0;
    logic       cons_valid = 1'b0;
    logic [1:0] cons_op = '0;
    logic [7:0] cons_idx = '0;
    logic [7:0] cons_set_idx = '0;
    logic       cons_grant, cons_stall, err_flag;
    logic [1:0] err_code;
    logic [7:0] err_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    event_flag_bank uut (
        .clk(clk), .rst(rst),
        .prod_valid(prod_valid), .prod_idx(prod_idx),
        .cons_valid(cons_valid), .cons_op(cons_op),
        .cons_idx(cons_idx), .cons_set_idx(cons_set_idx),
        .cons_grant(cons_grant), .cons_stall(cons_stall),
        .err_flag(err_flag), .err_code(err_code), .err_idx(err_idx)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; prod_valid = 1'b0; cons_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive one cycle at the falling edge, check grant/stall mid low phase,
    // let the rising edge commit, then drop the requests.
    task automatic step(input logic pv, input logic [7:0] pi,
                        input logic cv, input logic [1:0] op,
                        input logic [7:0] ci, input logic [7:0] cs,
                        input logic eg, input logic es, input string tag);
        @(negedge clk);
        prod_valid = pv; prod_idx = pi;
        cons_valid = cv; cons_op = op; cons_idx = ci; cons_set_idx = cs;
        #5;
        check({tag, " grant"}, {31'd0, cons_grant}, {31'd0, eg});
        check({tag, " stall"}, {31'd0, cons_stall}, {31'd0, es});
        @(posedge clk);
        #1;
        prod_valid = 1'b0; cons_valid = 1'b0;
    endtask

    task automatic raise(input logic [7:0] i, input string tag);
        step(1'b1, i, 1'b0, 2'b00, 8'd0, 8'd0, 1'b0, 1'b0, tag);
    endtask

    task automatic waitc(input logic [7:0] i, input logic eg, input string tag);
        step(1'b0, 8'd0, 1'b1, 2'b00, i, 8'd0, eg, ~eg, tag);
    endtask

    task automatic chk_err(input logic ef, input logic [1:0] ec, input logic [7:0] ei,
                           input string tag);
        check({tag, " err_flag"}, {31'd0, err_flag}, {31'd0, ef});
        check({tag, " err_code"}, {30'd0, err_code}, {30'd0, ec});
        check({tag, " err_idx"}, {24'd0, err_idx}, {24'd0, ei});
    endtask

    task automatic t_reset();
        do_reset();
        chk_err(1'b0, 2'b00, 8'd0, "R1 reset");
        waitc(8'd5, 1'b0, "R1 wait after reset");
    endtask

    task automatic t_independent();
        raise(8'd0, "R2 raise 0");
        raise(8'd255, "R2 raise 255");
        waitc(8'd1, 1'b0, "R2 neighbour 1");
        waitc(8'd0, 1'b1, "R3 wait 0");
        waitc(8'd0, 1'b0, "R3 consumed 0");
        waitc(8'd255, 1'b1, "R2 wait 255");
        waitc(8'd255, 1'b0, "R4 stall 255");
        chk_err(1'b0, 2'b00, 8'd0, "R3 no error");
    endtask

    task automatic t_same_cycle();
        step(1'b1, 8'd17, 1'b1, 2'b00, 8'd17, 8'd0, 1'b1, 1'b0, "R8 same cycle");
        waitc(8'd17, 1'b0, "R8 ends lowered");
        chk_err(1'b0, 2'b00, 8'd0, "R8 no error");
    endtask

    task automatic t_lower();
        raise(8'd40, "R6 raise 40");
        step(1'b0, 8'd0, 1'b1, 2'b01, 8'd40, 8'd0, 1'b1, 1'b0, "R6 lower 40");
        waitc(8'd40, 1'b0, "R6 lowered 40");
        chk_err(1'b0, 2'b00, 8'd0, "R6 no error");
    endtask

    task automatic t_wait_raise();
        raise(8'd60, "R7 raise 60");
        step(1'b0, 8'd0, 1'b1, 2'b10, 8'd60, 8'd61, 1'b1, 1'b0, "R7 wait60 raise61");
        waitc(8'd60, 1'b0, "R7 60 consumed");
        waitc(8'd61, 1'b1, "R7 61 raised");
        step(1'b0, 8'd0, 1'b1, 2'b10, 8'd63, 8'd62, 1'b0, 1'b1, "R7 blocked");
        waitc(8'd62, 1'b0, "R7 no raise when blocked");
        chk_err(1'b0, 2'b00, 8'd0, "R7 no error");
    endtask

    task automatic t_reserved();
        raise(8'd70, "R10 raise 70");
        step(1'b0, 8'd0, 1'b1, 2'b11, 8'd70, 8'd71, 1'b0, 1'b0, "R10 reserved op");
        waitc(8'd71, 1'b0, "R10 71 untouched");
        waitc(8'd70, 1'b1, "R10 70 kept");
    endtask

    task automatic t_dup();
        do_reset();
        raise(8'd90, "R5 raise 90");
        raise(8'd90, "R5 raise 90 again");
        chk_err(1'b1, 2'b01, 8'd90, "R5 double raise");
        waitc(8'd90, 1'b1, "R5 one pass");
        waitc(8'd90, 1'b0, "R5 only once");
    endtask

    task automatic t_lower_unset();
        do_reset();
        step(1'b0, 8'd0, 1'b1, 2'b01, 8'd100, 8'd0, 1'b1, 1'b0, "R6 lower unset");
        chk_err(1'b1, 2'b10, 8'd100, "R6 lower before raise");
        waitc(8'd100, 1'b0, "R6 stays lowered");
    endtask

    task automatic t_wait_raise_dup();
        do_reset();
        raise(8'd110, "R7 raise 110");
        raise(8'd111, "R7 raise 111");
        step(1'b0, 8'd0, 1'b1, 2'b10, 8'd110, 8'd111, 1'b1, 1'b0, "R7 dup target");
        chk_err(1'b1, 2'b01, 8'd111, "R7 dup target error");
        waitc(8'd110, 1'b0, "R7 wait part consumed");
        waitc(8'd111, 1'b1, "R7 target once");
        waitc(8'd111, 1'b0, "R7 target not doubled");
    endtask

    task automatic t_sticky();
        do_reset();
        raise(8'd120, "R9 raise 120");
        step(1'b1, 8'd120, 1'b1, 2'b01, 8'd121, 8'd0, 1'b1, 1'b0, "R9 two errors");
        chk_err(1'b1, 2'b01, 8'd120, "R9 producer wins");
        step(1'b0, 8'd0, 1'b1, 2'b01, 8'd122, 8'd0, 1'b1, 1'b0, "R9 later error");
        chk_err(1'b1, 2'b01, 8'd120, "R9 first kept");
    endtask

    task automatic t_reset_clears();
        raise(8'd130, "R11 raise 130");
        do_reset();
        chk_err(1'b0, 2'b00, 8'd0, "R11 error cleared");
        waitc(8'd130, 1'b0, "R11 flag cleared");
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_independent();
        t_same_cycle();
        t_lower();
        t_wait_raise();
        t_reserved();
        t_dup();
        t_lower_unset();
        t_wait_raise_dup();
        t_sticky();
        t_reset_clears();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule